// File: doc/BRIEF.md
# Stack Cache with Top Pointer and Random-Access Index

This block holds the most recently pushed part of a large software stack in a 1024 x 32-bit on-chip array. A top pointer always addresses the current top entry. A separately loadable index register can address any entry in the array, independently of the top pointer. Microcode can push, pop, replace the top entry, overwrite it in place, and read or write through the index. It can also load either register, or read it back as a zero-extended word.

The on-chip array is only a window onto a deeper stack kept in main memory. Two kinds of report let control code keep that window filled. Two level flags compare the pointer against programmable high and low thresholds. Two one-cycle pulses mark the moment the pointer wraps past either end of the array. The transfers to and from main memory are not part of this block.

Top module: `stack_window`

## Requirements
- R1: After reset the pointer and the index are 0 and both wrap pulses are low.
- R2: A push without a pop, in a cycle with no pointer load, increments the pointer modulo 1024 and writes `wrData` at the new pointer, so `topData` shows that word from the next cycle on.
- R3: `topData` always shows the entry at the pointer, and a pop without a push, in a cycle with no pointer load, decrements the pointer modulo 1024.
- R4: A push and a pop in the same cycle replace the top entry with `wrData` and leave the pointer unchanged.
- R5: `topWrEn` writes `wrData` at the current pointer without moving it. Combined with a pop, it writes at the old pointer and then the pointer moves down.
- R6: `idxData` always shows the entry at the index, and `idxWrEn` writes `idxWrData` there. When both the index port and the stack port write the same entry in one cycle, the stack-port data is kept.
- R7: `regWrEn` with `regSel`=0 loads the pointer, and with `regSel`=1 loads the index, from bits 9:0 of `regWrData`. A pointer load cancels any push, pop or top write in that cycle.
- R8: `regRdData` returns the pointer when `regSel`=0 and the index when `regSel`=1, with bits 31:10 reading zero.
- R9: `wrapUp` is high for exactly one cycle after a push that moves the pointer from 1023 to 0. `wrapDown` is high for exactly one cycle after a pop that moves it from 0 to 1023. The two are never high together.
- R10: `spillReq` is high while the pointer is greater than `hiThresh`, and `fillReq` is high while the pointer is less than `loThresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pushEn | input | 1 | Push `wrData` |
| popEn | input | 1 | Pop the top entry |
| topWrEn | input | 1 | Overwrite the entry at the pointer |
| wrData | input | 32 | Data for the stack port |
| topData | output | 32 | Entry at the pointer |
| idxWrEn | input | 1 | Write the entry at the index |
| idxWrData | input | 32 | Data for the index port |
| idxData | output | 32 | Entry at the index |
| regWrEn | input | 1 | Load the register picked by `regSel` |
| regSel | input | 1 | 0 selects the pointer, 1 selects the index |
| regWrData | input | 32 | Load value; bits 9:0 are used |
| regRdData | output | 32 | Selected register, zero-extended |
| hiThresh | input | 10 | Upper threshold for the spill request |
| loThresh | input | 10 | Lower threshold for the refill request |
| spillReq | output | 1 | Pointer is above `hiThresh` |
| fillReq | output | 1 | Pointer is below `loThresh` |
| wrapUp | output | 1 | Pulse after the pointer wraps from 1023 to 0 |
| wrapDown | output | 1 | Pulse after the pointer wraps from 0 to 1023 |

## Verification
On every cycle, the properties check how the pointer moves after a push, a pop, a replace or a load. They also check the data that appears on top after a push or a replace, the zero upper bits of the register read-back, the wrap pulses and their mutual exclusion. Only the bench's reference model can show that array contents survive later operations. The same holds for the index-port write losing a same-entry collision and for the threshold flags tracking reprogrammed limits. The bench compares all of these against the model on every clock, across directed cases and a long random mix of operations.

// File: rtl/stack_window_pkg.sv
package stack_window_pkg;
  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic ptrInc;    // pointer + 1
    logic ptrDec;    // pointer - 1
    logic ptrLoad;   // pointer <- load value
    logic idxLoad;   // index <- load value
    logic stkWrite;  // write wrData on the stack port
    logic stkNext;   // stack write goes to pointer + 1
    logic idxWrite;  // write idxWrData at the index
  } strobes_t;
endpackage

// File: rtl/stack_window_ctrl.sv
module stack_window_ctrl
  import stack_window_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic              topWrEn,
  input  logic              idxWrEn,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] hiThresh,
  input  logic [ADDR_W-1:0] loThresh,
  output strobes_t          strobes,
  output logic              spillReq,
  output logic              fillReq,
  output logic              wrapUp,
  output logic              wrapDown
);
  localparam logic [ADDR_W-1:0] PTR_MAX = '1;
  localparam logic [ADDR_W-1:0] PTR_MIN = '0;

  logic stackOk;

  always_comb begin
    strobes          = '0;
    strobes.ptrLoad  = regWrEn & ~regSel;
    strobes.idxLoad  = regWrEn & regSel;
    stackOk          = ~strobes.ptrLoad;
    strobes.ptrInc   = stackOk & pushEn & ~popEn;
    strobes.ptrDec   = stackOk & popEn & ~pushEn;
    strobes.stkWrite = stackOk & (pushEn | topWrEn);
    strobes.stkNext  = strobes.ptrInc;
    strobes.idxWrite = idxWrEn;
  end

  assign spillReq = ptr > hiThresh;
  assign fillReq  = ptr < loThresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrapUp   <= 1'b0;
      wrapDown <= 1'b0;
    end else begin
      wrapUp   <= strobes.ptrInc && (ptr == PTR_MAX);
      wrapDown <= strobes.ptrDec && (ptr == PTR_MIN);
    end
  end
endmodule

// File: rtl/stack_window_dp.sv
module stack_window_dp
  import stack_window_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] idxWrData,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] topData,
  output logic [DATA_W-1:0] idxData,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] ptrQ,
  output logic [ADDR_W-1:0] idxQ
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] stkAddr;
  logic [ADDR_W-1:0] loadVal;

  assign stkAddr = strobes.stkNext ? ptrQ + 1'b1 : ptrQ;
  assign loadVal = regWrData[ADDR_W-1:0];

  // index write first so a same-entry stack write overrides it
  always_ff @(posedge clk) begin
    if (strobes.idxWrite) mem[idxQ]    <= idxWrData;
    if (strobes.stkWrite) mem[stkAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      idxQ <= '0;
    end else begin
      if (strobes.ptrLoad)     ptrQ <= loadVal;
      else if (strobes.ptrInc) ptrQ <= ptrQ + 1'b1;
      else if (strobes.ptrDec) ptrQ <= ptrQ - 1'b1;
      if (strobes.idxLoad)     idxQ <= loadVal;
    end
  end

  assign topData   = mem[ptrQ];
  assign idxData   = mem[idxQ];
  assign regRdData = {{PAD_W{1'b0}}, (regSel ? idxQ : ptrQ)};
endmodule

// File: rtl/stack_window.sv
module stack_window
  import stack_window_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic              topWrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] topData,
  input  logic              idxWrEn,
  input  logic [DATA_W-1:0] idxWrData,
  output logic [DATA_W-1:0] idxData,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] hiThresh,
  input  logic [ADDR_W-1:0] loThresh,
  output logic              spillReq,
  output logic              fillReq,
  output logic              wrapUp,
  output logic              wrapDown
);
  strobes_t          strobes;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] idxQ;

  stack_window_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .topWrEn(topWrEn),
    .idxWrEn(idxWrEn), .regWrEn(regWrEn), .regSel(regSel), .ptr(ptrQ),
    .hiThresh(hiThresh), .loThresh(loThresh), .strobes(strobes),
    .spillReq(spillReq), .fillReq(fillReq), .wrapUp(wrapUp), .wrapDown(wrapDown)
  );

  stack_window_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regSel(regSel),
    .wrData(wrData), .idxWrData(idxWrData), .regWrData(regWrData),
    .topData(topData), .idxData(idxData), .regRdData(regRdData),
    .ptrQ(ptrQ), .idxQ(idxQ)
  );
endmodule

// File: rtl/stack_window_chk.sv
module stack_window_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushEn,
  input logic              popEn,
  input logic              regWrEn,
  input logic              regSel,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] topData,
  input logic [DATA_W-1:0] regRdData,
  input logic [ADDR_W-1:0] ptrQ,
  input logic              wrapUp,
  input logic              wrapDown
);
  localparam logic [ADDR_W-1:0] TOP_END = '1;
  logic ldPtr;
  assign ldPtr = regWrEn && !regSel;

  // R2
  push_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && !ldPtr) |=> ptrQ == ADDR_W'($past(ptrQ) + 1'b1));
  // R2
  push_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && !ldPtr) |=> topData == $past(wrData));
  // R3
  pop_retreat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && !ldPtr) |=> ptrQ == ADDR_W'($past(ptrQ) - 1'b1));
  // R4
  replace_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn && !ldPtr) |=> (ptrQ == $past(ptrQ)) && (topData == $past(wrData)));
  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldPtr |=> ptrQ == $past(regWrData[ADDR_W-1:0]));
  // R8
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:ADDR_W] == '0);
  // R9
  wrap_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrapUp, wrapDown}));
  // R9
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && !ldPtr && ptrQ == TOP_END) |=> wrapUp);
  // R9
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && !ldPtr && ptrQ == '0) |=> wrapDown);
endmodule

bind stack_window stack_window_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .regWrEn(regWrEn),
  .regSel(regSel), .wrData(wrData), .regWrData(regWrData), .topData(topData),
  .regRdData(regRdData), .ptrQ(ptrQ), .wrapUp(wrapUp), .wrapDown(wrapDown)
);

// File: tb/tb_stack_window.sv
module tb_stack_window;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushEn = 0, popEn = 0, topWrEn = 0, idxWrEn = 0, regWrEn = 0, regSel = 0;
  logic [31:0] wrData = 0, idxWrData = 0, regWrData = 0;
  logic [9:0]  hiThresh = 10'd1000, loThresh = 10'd2;
  logic [31:0] topData, idxData, regRdData;
  logic        spillReq, fillReq, wrapUp, wrapDown;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  logic [31:0] mMem [1024];
  bit          mVal [1024];
  int          mPtr = 0, mIdx = 0;
  bit          mWu = 0, mWd = 0;

  always #10 clk = ~clk;

  stack_window dut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .topWrEn(topWrEn),
    .wrData(wrData), .topData(topData), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .idxData(idxData), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .hiThresh(hiThresh), .loThresh(loThresh),
    .spillReq(spillReq), .fillReq(fillReq), .wrapUp(wrapUp), .wrapDown(wrapDown)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    if (mVal[mPtr]) chk("R2 R3 R5 topData", topData, mMem[mPtr]);
    if (mVal[mIdx]) chk("R6 idxData", idxData, mMem[mIdx]);
    chk("R7 R8 regRdData", regRdData, regSel ? 32'(mIdx) : 32'(mPtr));
    chk("R10 spillReq", 32'(spillReq), 32'(mPtr > int'(hiThresh)));
    chk("R10 fillReq", 32'(fillReq), 32'(mPtr < int'(loThresh)));
    chk("R9 wrapUp", 32'(wrapUp), 32'(mWu));
    chk("R9 wrapDown", 32'(wrapDown), 32'(mWd));
  endtask

  // drive at negedge, let one edge pass, update model, compare at next negedge
  task automatic cyc(bit pu, bit po, bit tw, bit iw, bit rw, bit sel,
                     logic [31:0] wd, logic [31:0] iwd, logic [31:0] rwd);
    bit ld;
    int nPtr;
    pushEn = pu; popEn = po; topWrEn = tw; idxWrEn = iw;
    regWrEn = rw; regSel = sel; wrData = wd; idxWrData = iwd; regWrData = rwd;
    @(posedge clk);
    ld = rw && !sel;
    nPtr = mPtr;
    if (iw) begin mMem[mIdx] = iwd; mVal[mIdx] = 1; end
    mWu = 0; mWd = 0;
    if (!ld) begin
      if (pu && !po) begin
        nPtr = (mPtr + 1) % 1024;
        mMem[nPtr] = wd; mVal[nPtr] = 1;
        mWu = (mPtr == 1023);
      end else begin
        if (pu || tw) begin mMem[mPtr] = wd; mVal[mPtr] = 1; end
        if (po && !pu) begin nPtr = (mPtr + 1023) % 1024; mWd = (mPtr == 0); end
      end
    end else nPtr = int'(rwd[9:0]);
    if (rw && sel) mIdx = int'(rwd[9:0]);
    mPtr = nPtr;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0,0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", regRdData, 0);
    chk("R1 wrapUp", 32'(wrapUp), 0);
    chk("R1 wrapDown", 32'(wrapDown), 0);
    regSel = 1; #1;
    chk("R1 idx", regRdData, 0);
    regSel = 0;
    rstN = 1;
    @(negedge clk);
    compareAll();
    // R2 pushes
    for (int i = 0; i < 5; i++) cyc(1,0,0,0,0,0, 32'hA000_0000 + i, 0, 0);
    chk("R2 ptr after 5 pushes", regRdData, 5);
    // R3 pops
    cyc(0,1,0,0,0,0,0,0,0);
    cyc(0,1,0,0,0,0,0,0,0);
    chk("R3 ptr after pops", regRdData, 3);
    chk("R3 top after pops", topData, 32'hA000_0002);
    // R4 replace
    cyc(1,1,0,0,0,0, 32'hBEEF_0004, 0, 0);
    chk("R4 replace top", topData, 32'hBEEF_0004);
    // R5 top write, and top write with pop
    cyc(0,0,1,0,0,0, 32'hC0DE_0005, 0, 0);
    cyc(0,1,1,0,0,0, 32'hC0DE_0006, 0, 0);
    chk("R5 ptr after write+pop", regRdData, 2);
    // R6 index load, write, read
    cyc(0,0,0,0,1,1,0,0, 32'd3);
    chk("R6 idx reads written entry", idxData, 32'hC0DE_0006);
    cyc(0,0,0,1,0,1,0, 32'h1D00_0003, 0);
    cyc(0,0,0,0,1,1,0,0, 32'd2);
    // R6 collision: index and stack both write entry 2, stack wins
    cyc(0,0,1,1,0,1, 32'h5555_0002, 32'h6666_0002, 0);
    chk("R6 collision keeps stack data", idxData, 32'h5555_0002);
    // R7 pointer load cancels push
    cyc(1,0,0,0,1,0, 32'hDEAD_0000, 0, 32'd1022);
    chk("R7 ptr load wins", regRdData, 1022);
    // R9 wrap up
    cyc(1,0,0,0,0,0, 32'h7000_03FF, 0, 0);
    cyc(1,0,0,0,0,0, 32'h7000_0000, 0, 0);
    chk("R9 wrap up pulse", 32'(wrapUp), 1);
    idle();
    chk("R9 wrap up single cycle", 32'(wrapUp), 0);
    cyc(0,1,0,0,0,0,0,0,0);
    chk("R9 wrap down pulse", 32'(wrapDown), 1);
    chk("R9 ptr after wrap down", regRdData, 1023);
    // R8 zero-extension with upper load bits set
    cyc(0,0,0,0,1,0,0,0, 32'hFFFF_F003);
    chk("R8 read back zero-extended", regRdData, 3);
    // R10 thresholds reprogrammed
    hiThresh = 10'd2; loThresh = 10'd5; idle();
    chk("R10 both flags", {30'd0, spillReq, fillReq}, 32'd3);
    hiThresh = 10'd3; loThresh = 10'd3; idle();
    chk("R10 at thresholds", {30'd0, spillReq, fillReq}, 32'd0);
    // random mix
    hiThresh = 10'd600; loThresh = 10'd40;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 45, (r >= 30 && r < 70), (r % 7) == 0, (r % 5) == 0,
          (r >= 97), r[0], $urandom, $urandom, $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule